// File: doc/BRIEF.md
# Encoder Input Conditioner

This block cleans up the three raw lines of an incremental encoder (phase A, phase B and the index mark) before they reach an edge detector. Each line is first brought into the system clock domain through a two-flop synchroniser. Each line can then be inverted on its own. The two phase lines can be exchanged. Inversion always happens before the exchange.

An optional glitch filter samples the conditioned lines on a prescaled tick. The tick interval is the prescale value plus two system clocks. A filtered output changes only after the line has shown the same new level on three consecutive ticks. When the filter is off, the conditioned levels go straight to the outputs. When the prescale value changes, the tick counter starts over, so the first interval at the new setting is complete.

Top module: `enc_input_cond`

## Requirements
- R1: Each raw input passes through two synchronising flops. With the filter off, a raw change made between clock edges appears at the output after exactly two rising edges, and not after one.
- R2: With `filt_en` = 0, each output equals the inverted and swapped synchronised input, with no stability check.
- R3: `inv_a`, `inv_b` and `inv_idx` each invert only their own line (1 = inverted). They act at the output without further delay when the filter is off.
- R4: With `swap` = 1, `out_a` carries the phase B path and `out_b` carries the phase A path. The index line is never swapped.
- R5: Inversion is applied before the swap. With `swap` = 1 and `inv_a` = 1, the raw A line reaches `out_b` inverted.
- R6: With `filt_en` = 1, the lines are sampled once every `presc` + 2 clocks (`presc` = 0 gives 2, `presc` = 15 gives 17).
- R7: With `filt_en` = 1, a filtered output takes a new level only when the three most recent samples all show that level. A pulse lasting at most 2·(`presc`+2) clocks never reaches the output.
- R8: While `rst_n` is low, all outputs, synchroniser flops, sample histories and the tick counter are cleared to 0.
- R9: A change of `presc` restarts the tick counter. The first tick at the new setting comes `presc`+2 clocks after the clock edge that saw the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_a | input | 1 | Raw phase A line |
| raw_b | input | 1 | Raw phase B line |
| raw_idx | input | 1 | Raw index line |
| filt_en | input | 1 | 1 = glitch filter active |
| presc | input | 4 | Tick interval minus two, in clocks |
| inv_a | input | 1 | Invert phase A |
| inv_b | input | 1 | Invert phase B |
| inv_idx | input | 1 | Invert index |
| swap | input | 1 | Exchange phase A and phase B after inversion |
| out_a | output | 1 | Conditioned phase A |
| out_b | output | 1 | Conditioned phase B |
| out_idx | output | 1 | Conditioned index |

## Verification
In pass-through mode, a raw change is due at the output two rising edges later. The inversion and swap controls act in the same cycle they are set. The bench drives inputs on falling edges and samples one and two falling edges later, so that both the early and the due value are checked. In filter mode, the phase of the tick is not visible at the ports, so the bench checks a window instead. The output must still hold the old level after 2·`presc`+6 edges and must show the new level after 3·`presc`+8 edges. Glitches of 2·(`presc`+2) clocks are watched on every cycle until they could no longer propagate. The exact tick spacing, including the restart after a prescale change, is checked by a cycle counter in the checker.

// File: rtl/enc_input_cond.sv
module enc_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_W     = 4,
  parameter int STABLE_CNT  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               raw_a,
  input  logic               raw_b,
  input  logic               raw_idx,
  input  logic               filt_en,
  input  logic [PRESC_W-1:0] presc,
  input  logic               inv_a,
  input  logic               inv_b,
  input  logic               inv_idx,
  input  logic               swap,
  output logic               out_a,
  output logic               out_b,
  output logic               out_idx
);
  localparam int NSIG  = 3;
  localparam int CNT_W = PRESC_W + 1;

  logic [NSIG-1:0]    sync_q [SYNC_STAGES];
  logic [NSIG-1:0]    inv_v, cond, filt_q, outs;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   cnt, cnt_end;
  logic               presc_chg, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= {raw_idx, raw_b, raw_a};
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign inv_v = sync_q[SYNC_STAGES-1] ^ {inv_idx, inv_b, inv_a};
  assign cond  = {inv_v[2], swap ? inv_v[0] : inv_v[1], swap ? inv_v[1] : inv_v[0]};

  assign presc_chg = presc != presc_q;
  assign cnt_end   = {1'b0, presc_q} + CNT_W'(1);
  assign tick      = !presc_chg && (cnt == cnt_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt     <= '0;
    end else if (presc_chg) begin
      presc_q <= presc;
      cnt     <= '0;
    end else if (tick) begin
      cnt     <= '0;
    end else begin
      cnt     <= cnt + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NSIG; g++) begin : g_filt
    logic [STABLE_CNT-2:0] hist;
    logic [STABLE_CNT-1:0] window;
    logic                  level;
    assign window = {hist, cond[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist  <= '0;
        level <= 1'b0;
      end else if (tick) begin
        hist <= window[STABLE_CNT-2:0];
        if (&window)       level <= 1'b1;
        else if (~|window) level <= 1'b0;
      end
    end
    assign filt_q[g] = level;
  end

  assign outs    = filt_en ? filt_q : cond;
  assign out_a   = outs[0];
  assign out_b   = outs[1];
  assign out_idx = outs[2];
endmodule

// File: rtl/enc_input_cond_chk.sv
module enc_input_cond_chk #(
  parameter int PRESC_W    = 4,
  parameter int STABLE_CNT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               raw_idx,
  input logic               inv_idx,
  input logic               filt_en,
  input logic [PRESC_W-1:0] presc,
  input logic               out_a,
  input logic               out_b,
  input logic               out_idx,
  input logic               tick,
  input logic [2:0]         cond,
  input logic [2:0]         filt_q
);
  localparam int SW = PRESC_W + 2;

  logic [1:0]            age;
  logic [SW-1:0]         since;
  logic [PRESC_W-1:0]    pr_q;
  logic [STABLE_CNT-1:0] ha;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age   <= '0;
      since <= SW'(1);
      pr_q  <= '0;
      ha    <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      pr_q <= presc;
      if (tick || presc != pr_q) since <= SW'(1);
      else if (since != '1)      since <= since + SW'(1);
      if (tick) ha <= {ha[STABLE_CNT-2:0], cond[0]};
    end
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !filt_en) |-> (out_idx == ($past(raw_idx, 2) ^ inv_idx))); // R1

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (since == SW'(presc) + SW'(2))); // R9

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && filt_en && $past(filt_en) && !$past(tick)) |-> $stable({out_a, out_b, out_idx})); // R7

  AST_THREE_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(tick) && filt_q[0] != $past(filt_q[0])) |-> (ha == {STABLE_CNT{filt_q[0]}})); // R7

  always_ff @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (filt_q == 3'b000 && tick == 1'b0); // R8
  end
endmodule

bind enc_input_cond enc_input_cond_chk #(.PRESC_W(PRESC_W), .STABLE_CNT(STABLE_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_idx(raw_idx), .inv_idx(inv_idx), .filt_en(filt_en),
  .presc(presc), .out_a(out_a), .out_b(out_b), .out_idx(out_idx), .tick(tick),
  .cond(cond), .filt_q(filt_q)
);

// File: tb/enc_input_cond_bench.sv
module enc_input_cond_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_a = 1'b0, raw_b = 1'b0, raw_idx = 1'b0;
  logic filt_en = 1'b0;
  logic [3:0] presc = 4'd0;
  logic inv_a = 1'b0, inv_b = 1'b0, inv_idx = 1'b0, swap = 1'b0;
  logic out_a, out_b, out_idx;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  enc_input_cond u_enc_input_cond (
    .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b), .raw_idx(raw_idx),
    .filt_en(filt_en), .presc(presc), .inv_a(inv_a), .inv_b(inv_b), .inv_idx(inv_idx),
    .swap(swap), .out_a(out_a), .out_b(out_b), .out_idx(out_idx)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic fe, input logic [3:0] p, input logic ia,
                         input logic ib, input logic ii, input logic sw);
    filt_en = fe; presc = p; inv_a = ia; inv_b = ib; inv_idx = ii; swap = sw;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_cfg(1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    {raw_idx, raw_b, raw_a} = 3'b111;
    wait_n(3);
    chk("R8", "outputs in reset", {out_idx, out_b, out_a}, 0);
    {raw_idx, raw_b, raw_a} = 3'b000;
    rst_n = 1'b1;
    wait_n(1);
    chk("R8", "outputs after reset release", {out_idx, out_b, out_a}, 0);
  endtask

  task automatic t_passthru();
    set_cfg(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    {raw_idx, raw_b, raw_a} = 3'b000;
    wait_n(4);
    raw_a = 1'b1;
    wait_n(1);
    chk("R1", "out_a after one edge", out_a, 0);
    wait_n(1);
    chk("R1", "out_a after two edges", out_a, 1);
    raw_idx = 1'b1;
    wait_n(1);
    chk("R2", "out_idx after one edge", out_idx, 0);
    wait_n(1);
    chk("R2", "out_idx after two edges", out_idx, 1);
    chk("R2", "out_b untouched", out_b, 0);
  endtask

  task automatic t_invert();
    set_cfg(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    {raw_idx, raw_b, raw_a} = 3'b000;
    wait_n(4);
    inv_a = 1'b1;
    wait_n(1);
    chk("R3", "inv_a alone", {out_idx, out_b, out_a}, 3'b001);
    inv_a = 1'b0; inv_b = 1'b1;
    wait_n(1);
    chk("R3", "inv_b alone", {out_idx, out_b, out_a}, 3'b010);
    inv_b = 1'b0; inv_idx = 1'b1;
    wait_n(1);
    chk("R3", "inv_idx alone", {out_idx, out_b, out_a}, 3'b100);
    inv_idx = 1'b0;
  endtask

  task automatic t_swap();
    set_cfg(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    {raw_idx, raw_b, raw_a} = 3'b001;
    wait_n(3);
    chk("R4", "swap with A high", {out_idx, out_b, out_a}, 3'b010);
    {raw_idx, raw_b, raw_a} = 3'b110;
    wait_n(3);
    chk("R4", "swap with B and idx high", {out_idx, out_b, out_a}, 3'b101);
  endtask

  task automatic t_order();
    set_cfg(1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    {raw_idx, raw_b, raw_a} = 3'b000;
    wait_n(3);
    chk("R5", "inv_a then swap", {out_idx, out_b, out_a}, 3'b010);
    inv_a = 1'b0; inv_b = 1'b1;
    wait_n(1);
    chk("R5", "inv_b then swap", {out_idx, out_b, out_a}, 3'b001);
    set_cfg(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_filter(input int p);
    int bad;
    set_cfg(1'b1, p[3:0], 1'b0, 1'b0, 1'b0, 1'b0);
    {raw_idx, raw_b, raw_a} = 3'b000;
    wait_n(3 * p + 20);
    chk("R7", $sformatf("settled low p=%0d", p), {out_idx, out_b, out_a}, 0);
    raw_a = 1'b1;
    wait_n(2 * p + 6);
    chk("R6", $sformatf("out_a still old p=%0d", p), out_a, 0);
    wait_n(p + 2);
    chk("R6", $sformatf("out_a new by deadline p=%0d", p), out_a, 1);
    raw_a = 1'b0;
    bad = 0;
    for (int k = 0; k < 3 * p + 14; k++) begin
      if (k == 2 * p + 4) raw_a = 1'b1;
      wait_n(1);
      if (out_a !== 1'b1) bad++;
    end
    chk("R7", $sformatf("low glitch rejected p=%0d", p), bad, 0);
    raw_idx = 1'b1;
    bad = 0;
    for (int k = 0; k < p + 12; k++) begin
      if (k == 1) raw_idx = 1'b0;
      wait_n(1);
      if (out_idx !== 1'b0) bad++;
    end
    chk("R7", $sformatf("one-cycle idx glitch rejected p=%0d", p), bad, 0);
  endtask

  task automatic t_restart();
    set_cfg(1'b1, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0);
    {raw_idx, raw_b, raw_a} = 3'b000;
    wait_n(70);
    wait_n(7);
    presc = 4'd0;
    raw_b = 1'b1;
    wait_n(6);
    chk("R9", "out_b old before restarted ticks", out_b, 0);
    wait_n(2);
    chk("R9", "out_b new after restart", out_b, 1);
  endtask

  initial begin
    wait_n(1);
    t_reset();
    t_passthru();
    t_invert();
    t_swap();
    t_order();
    t_filter(0);
    t_filter(5);
    t_filter(15);
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule